// File: doc/BRIEF.md
# Linked-List Frame Fetch Engine

This block is a read-only bus master that feeds a display pipeline. It walks a chain of frame descriptors held in system memory. Each descriptor is four 32-bit words, read in a fixed order: the byte address of the next descriptor, the byte address of the frame buffer, a frame tag, and a command word. The command word holds the frame length as a count of 32-bit words, along with flags that request a start-of-frame pulse, request an end-of-frame pulse, or mark the buffer as starting with palette entries.

After a descriptor is read, the engine moves the frame data into an internal pixel FIFO. It uses bursts whose size is chosen by a two-bit select. Then it jumps to the descriptor named by the next field. A descriptor that links back to itself makes the same frame repeat without software doing anything.

Software points the engine at the first descriptor and raises the run enable. Lowering the enable lets the frame in progress finish and then parks the engine. The downstream consumer pops words from the FIFO. A pop while the FIFO is empty is recorded as an underrun.

Top module: `frame_desc_fetcher`

## Requirements
- R1: When the engine leaves idle with run_en high, it samples desc_ptr. It then issues a 4-word read at that byte address and takes the returned beats as next pointer, buffer address, frame tag and command, in that order.
- R2: During and after reset, and before the first enable, rd_req_valid, pix_valid, irq_sof, irq_eof, ufl_flag, irq_ufl and busy are all 0.
- R3: Command bits 11:0 give the frame length N in words. Exactly N words, read from consecutive addresses starting at the buffer address, appear in order on pix_data. N = 0 fetches no data.
- R4: burst_sel selects the burst size: 0 gives 4 words, 1 gives 8, 2 gives 16, and 3 is treated as 4. Every data request has the full burst size, except the last one of a frame, which carries only the remaining words.
- R5: Once rd_req_valid is raised, it stays high with rd_req_addr and rd_req_len unchanged until rd_req_ready is seen.
- R6: A data burst is requested only when the FIFO's free space is at least the full selected burst size. No returned word is ever dropped.
- R7: After the last word of a frame, the next descriptor is read from the previous descriptor's next field. A descriptor whose next field is its own address replays its frame indefinitely.
- R8: When command bit 15 is set, irq_sof pulses for one cycle right after the descriptor is loaded. cur_frame_id takes that descriptor's tag in the same cycle.
- R9: When command bit 16 is set, irq_eof pulses for one cycle after every word of that frame has been received.
- R10: pix_pal equals command bit 12 of the frame each output word belongs to.
- R11: Deasserting run_en lets the current descriptor's frame complete, after which busy drops and no further requests are made. A later enable restarts from desc_ptr.
- R12: A pop while pix_valid is 0 sets ufl_flag, which stays set until the next rising edge of run_en. irq_ufl follows ufl_flag unless ufl_mask is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable |
| desc_ptr | input | AW | Byte address of the first descriptor |
| burst_sel | input | 2 | Burst size select |
| ufl_mask | input | 1 | Masks the underrun interrupt |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read byte address |
| rd_req_len | output | 5 | Read length in words |
| rd_rsp_valid | input | 1 | Read data beat valid |
| rd_rsp_data | input | 32 | Read data beat |
| pix_pop | input | 1 | Consumer pops one word |
| pix_valid | output | 1 | FIFO head word valid |
| pix_data | output | 32 | FIFO head word |
| pix_pal | output | 1 | Head word belongs to a palette-marked frame |
| cur_frame_id | output | 32 | Tag of the loaded descriptor |
| irq_sof | output | 1 | Start-of-frame pulse |
| irq_eof | output | 1 | End-of-frame pulse |
| ufl_flag | output | 1 | Sticky underrun status |
| irq_ufl | output | 1 | Underrun interrupt |
| busy | output | 1 | Engine not idle |

## Verification
Several properties are checked on every cycle:
- request stability while stalled, and the bounds on request length;
- the FIFO never being pushed while full;
- single-cycle start-of-frame pulses;
- the return to idle after a stop;
- the setting of the underrun flag.

The remaining behaviour only shows up across a bench scenario: the order of descriptor and burst addresses, the shortened final burst, the word-exact data stream with its palette tag, the frame-tag and interrupt timing against received data, the link-following through zero-length and self-linked descriptors, and the frame boundary at which a stop takes effect.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DREQ,
      ST_DRSP,
      ST_BREQ,
      ST_BRSP,
      ST_DONE
   } fdf_state_e;

   localparam int unsigned CMD_PAL_BIT = 12;
   localparam int unsigned CMD_SOF_BIT = 15;
   localparam int unsigned CMD_EOF_BIT = 16;
   localparam int unsigned DESC_WORDS  = 4;
   localparam int unsigned MAX_BURST   = 16;

   function automatic logic [4:0] burst_words(input logic [1:0] sel);
      case (sel)
         2'd1:    return 5'd8;
         2'd2:    return 5'd16;
         default: return 5'd4;
      endcase
   endfunction

endpackage

// File: rtl/fdf_fifo.sv
module fdf_fifo #(
   parameter int unsigned WIDTH = 33,
   parameter int unsigned DEPTH = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [WIDTH-1:0]         din,
   input  logic                     pop,
   output logic [WIDTH-1:0]         dout,
   output logic                     empty,
   output logic                     full,
   output logic [$clog2(DEPTH):0]   level
);
   localparam int unsigned PW   = $clog2(DEPTH);
   localparam int unsigned LW   = PW + 1;
   localparam bit          POW2 = (DEPTH == (1 << PW));

   if (DEPTH < 16) begin : g_depth_chk
      $error("fdf_fifo: DEPTH must hold a 16-word burst");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + PW'(1);
      assign rd_nxt = rd_ptr + PW'(1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= din;
   end

   assign dout  = store[rd_ptr];
   assign empty = (level == '0);
   assign full  = (level == LW'(DEPTH));

   // R6: the sequencer never pushes into a full FIFO
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   p_level_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (level == $past(level) + LW'(1)));

endmodule

// File: rtl/fdf_burst_sizer.sv
module fdf_burst_sizer
   import fdf_pkg::*;
#(
   parameter int unsigned LEN_W = 12
) (
   input  logic [1:0]       burst_sel,
   input  logic [LEN_W-1:0] remaining,
   output logic [4:0]       full_words,
   output logic [4:0]       beat_words
);
   assign full_words = burst_words(burst_sel);

   if (LEN_W > 5) begin : g_wide
      assign beat_words = (remaining < LEN_W'(full_words)) ? remaining[4:0] : full_words;
   end else begin : g_narrow
      logic [4:0] rem5;
      assign rem5       = 5'(remaining);
      assign beat_words = (rem5 < full_words) ? rem5 : full_words;
   end

endmodule

// File: rtl/fdf_seq.sv
module fdf_seq
   import fdf_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned LEN_W      = 12,
   parameter int unsigned FIFO_DEPTH = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           run_en,
   input  logic [AW-1:0]                  desc_ptr,
   input  logic [1:0]                     burst_sel,
   input  logic [$clog2(FIFO_DEPTH):0]    fifo_level,
   output logic                           req_valid,
   input  logic                           req_ready,
   output logic [AW-1:0]                  req_addr,
   output logic [4:0]                     req_len,
   input  logic                           rsp_valid,
   input  logic [31:0]                    rsp_data,
   output logic                           push_valid,
   output logic [32:0]                    push_data,
   output logic [31:0]                    frame_id,
   output logic                           irq_sof,
   output logic                           irq_eof,
   output logic                           busy
);
   localparam int unsigned LVL_W = $clog2(FIFO_DEPTH) + 1;

   if (AW < 8 || AW > 32) begin : g_aw_chk
      $error("fdf_seq: AW must be 8..32");
   end
   if (LEN_W < 1 || LEN_W > CMD_PAL_BIT) begin : g_len_chk
      $error("fdf_seq: LEN_W must stay below the flag bits");
   end

   fdf_state_e       state;
   logic [AW-1:0]    cur_desc, next_r, buf_r;
   logic [31:0]      id_r, cmd_r;
   logic [LEN_W-1:0] remaining;
   logic [4:0]       bleft, full_words, beat_words;
   logic [1:0]       dbeat;
   logic [LVL_W-1:0] free_words;
   logic             room, req_fire;

   fdf_burst_sizer #(.LEN_W(LEN_W)) u_sizer (
      .burst_sel  (burst_sel),
      .remaining  (remaining),
      .full_words (full_words),
      .beat_words (beat_words)
   );

   assign free_words = LVL_W'(FIFO_DEPTH) - fifo_level;
   assign room       = free_words >= LVL_W'(full_words);
   assign req_valid  = (state == ST_DREQ) || ((state == ST_BREQ) && room);
   assign req_addr   = (state == ST_DREQ) ? cur_desc : buf_r;
   assign req_len    = (state == ST_DREQ) ? 5'(DESC_WORDS) : beat_words;
   assign req_fire   = req_valid && req_ready;
   assign push_valid = (state == ST_BRSP) && rsp_valid;
   assign push_data  = {cmd_r[CMD_PAL_BIT], rsp_data};
   assign busy       = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_desc  <= '0;
         next_r    <= '0;
         buf_r     <= '0;
         id_r      <= '0;
         cmd_r     <= '0;
         remaining <= '0;
         bleft     <= '0;
         dbeat     <= '0;
         frame_id  <= '0;
         irq_sof   <= 1'b0;
         irq_eof   <= 1'b0;
      end else begin
         irq_sof <= 1'b0;
         irq_eof <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (run_en) begin
                  cur_desc <= desc_ptr;
                  state    <= ST_DREQ;
               end
            end
            ST_DREQ: begin
               if (req_fire) begin
                  dbeat <= '0;
                  state <= ST_DRSP;
               end
            end
            ST_DRSP: begin
               if (rsp_valid) begin
                  dbeat <= dbeat + 2'd1;
                  case (dbeat)
                     2'd0: next_r <= rsp_data[AW-1:0];
                     2'd1: buf_r  <= rsp_data[AW-1:0];
                     2'd2: id_r   <= rsp_data;
                     default: begin
                        cmd_r     <= rsp_data;
                        remaining <= rsp_data[LEN_W-1:0];
                        frame_id  <= id_r;
                        irq_sof   <= rsp_data[CMD_SOF_BIT];
                        state     <= (rsp_data[LEN_W-1:0] == '0) ? ST_DONE : ST_BREQ;
                     end
                  endcase
               end
            end
            ST_BREQ: begin
               if (req_fire) begin
                  buf_r     <= buf_r + (AW'(beat_words) << 2);
                  remaining <= remaining - LEN_W'(beat_words);
                  bleft     <= beat_words;
                  state     <= ST_BRSP;
               end
            end
            ST_BRSP: begin
               if (rsp_valid) begin
                  bleft <= bleft - 5'd1;
                  if (bleft == 5'd1) begin
                     state <= (remaining == '0) ? ST_DONE : ST_BREQ;
                  end
               end
            end
            ST_DONE: begin
               irq_eof  <= cmd_r[CMD_EOF_BIT];
               cur_desc <= next_r;
               state    <= run_en ? ST_DREQ : ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5: a stalled request is held unchanged
   p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

   // R4: request length is never zero and never above the largest burst
   p_req_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len != 5'd0 && req_len <= 5'(MAX_BURST)));

   // R8: start-of-frame is a single-cycle pulse
   p_sof_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_sof |=> !irq_sof);

   // R11: finishing a frame with the enable low parks the engine
   p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && !run_en) |=> (!busy && !req_valid));

endmodule

// File: rtl/frame_desc_fetcher.sv
module frame_desc_fetcher #(
   parameter int unsigned AW           = 32,
   parameter int unsigned LEN_W        = 12,
   parameter int unsigned FIFO_DEPTH   = 32,
   parameter bit          UFL_MASKABLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic [AW-1:0] desc_ptr,
   input  logic [1:0]    burst_sel,
   input  logic          ufl_mask,
   output logic          rd_req_valid,
   input  logic          rd_req_ready,
   output logic [AW-1:0] rd_req_addr,
   output logic [4:0]    rd_req_len,
   input  logic          rd_rsp_valid,
   input  logic [31:0]   rd_rsp_data,
   input  logic          pix_pop,
   output logic          pix_valid,
   output logic [31:0]   pix_data,
   output logic          pix_pal,
   output logic [31:0]   cur_frame_id,
   output logic          irq_sof,
   output logic          irq_eof,
   output logic          ufl_flag,
   output logic          irq_ufl,
   output logic          busy
);
   localparam int unsigned LVL_W = $clog2(FIFO_DEPTH) + 1;

   logic             push_valid;
   logic [32:0]      push_data, head;
   logic             fifo_empty, fifo_full;
   logic [LVL_W-1:0] fifo_level;
   logic             run_q, run_rise;

   fdf_seq #(.AW(AW), .LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .desc_ptr   (desc_ptr),
      .burst_sel  (burst_sel),
      .fifo_level (fifo_level),
      .req_valid  (rd_req_valid),
      .req_ready  (rd_req_ready),
      .req_addr   (rd_req_addr),
      .req_len    (rd_req_len),
      .rsp_valid  (rd_rsp_valid),
      .rsp_data   (rd_rsp_data),
      .push_valid (push_valid),
      .push_data  (push_data),
      .frame_id   (cur_frame_id),
      .irq_sof    (irq_sof),
      .irq_eof    (irq_eof),
      .busy       (busy)
   );

   fdf_fifo #(.WIDTH(33), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_valid),
      .din   (push_data),
      .pop   (pix_pop),
      .dout  (head),
      .empty (fifo_empty),
      .full  (fifo_full),
      .level (fifo_level)
   );

   assign pix_valid = !fifo_empty;
   assign pix_data  = head[31:0];
   assign pix_pal   = head[32];
   assign run_rise  = run_en && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         ufl_flag <= 1'b0;
      end else begin
         run_q <= run_en;
         if (run_rise)                 ufl_flag <= 1'b0;
         else if (pix_pop && fifo_empty) ufl_flag <= 1'b1;
      end
   end

   if (UFL_MASKABLE) begin : g_ufl_mask
      assign irq_ufl = ufl_flag && !ufl_mask;
   end else begin : g_ufl_raw
      assign irq_ufl = ufl_flag;
   end

   // R12: a pop on an empty FIFO is recorded
   p_ufl_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_pop && !pix_valid && !run_rise) |=> ufl_flag);

   // R6: no push arrives while the FIFO is full
   p_push_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid |-> !fifo_full);

endmodule

// File: tb/frame_desc_fetcher_test.sv
module frame_desc_fetcher_test;
   localparam int unsigned AW = 32;
   localparam int unsigned FIFO_DEPTH = 32;
   localparam int unsigned DBASE = 32'h4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [31:0] desc_ptr = '0;
   logic [1:0]  burst_sel = '0;
   logic        ufl_mask = 1'b0;
   logic        rd_req_valid, rd_req_ready = 1'b0;
   logic [31:0] rd_req_addr;
   logic [4:0]  rd_req_len;
   logic        rd_rsp_valid = 1'b0;
   logic [31:0] rd_rsp_data = '0;
   logic        pix_pop = 1'b0;
   logic        pix_valid, pix_pal;
   logic [31:0] pix_data, cur_frame_id;
   logic        irq_sof, irq_eof, ufl_flag, irq_ufl, busy;

   always #2 clk = ~clk;

   frame_desc_fetcher #(.AW(AW), .FIFO_DEPTH(FIFO_DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .desc_ptr(desc_ptr),
      .burst_sel(burst_sel), .ufl_mask(ufl_mask),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .pix_pop(pix_pop), .pix_valid(pix_valid), .pix_data(pix_data), .pix_pal(pix_pal),
      .cur_frame_id(cur_frame_id), .irq_sof(irq_sof), .irq_eof(irq_eof),
      .ufl_flag(ufl_flag), .irq_ufl(irq_ufl), .busy(busy)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] mem [0:6143];
   int unsigned d_next [0:15];
   int unsigned d_buf  [0:15];
   int unsigned d_id   [0:15];
   int unsigned d_cmd  [0:15];

   logic [32:0] exp_q [$];
   int unsigned rq_addr [$];
   int unsigned rq_len  [$];
   bit          rq_desc [$];
   int unsigned fb_words [$];
   int unsigned fb_reqs  [$];
   int unsigned fb_sof   [$];
   int unsigned fb_eof   [$];
   int unsigned sof_id_q [$];
   int unsigned eof_words_q [$];

   int unsigned popped = 0, req_seen = 0, data_rx = 0, sof_cnt = 0, eof_cnt = 0;
   int unsigned pop_pct = 50;
   int unsigned cur_bw = 4;
   bit force_pop = 1'b0;
   bit cur_is_desc = 1'b1;
   bit stall_prev = 1'b0;
   logic [31:0] stall_addr;
   logic [4:0]  stall_len;

   function automatic logic [31:0] pat(input int unsigned i);
      return (i * 32'h01000193) ^ 32'h5A5A0000;
   endfunction

   function automatic int unsigned bw_of(input int unsigned bsel);
      return (bsel == 1) ? 8 : (bsel == 2) ? 16 : 4;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic set_desc(input int unsigned idx, input int unsigned nidx,
                           input int unsigned bufb, input int unsigned id,
                           input int unsigned cmd);
      d_next[idx] = nidx; d_buf[idx] = bufb; d_id[idx] = id; d_cmd[idx] = cmd;
      mem[DBASE/4 + idx*4 + 0] = DBASE + nidx*16;
      mem[DBASE/4 + idx*4 + 1] = bufb;
      mem[DBASE/4 + idx*4 + 2] = id;
      mem[DBASE/4 + idx*4 + 3] = cmd;
   endtask

   task automatic build_exp(input int unsigned start, input int unsigned bsel, input int nf);
      int unsigned idx = start;
      int unsigned words = 0, reqs = 0, sofs = 0, eofs = 0;
      int unsigned bw = bw_of(bsel);
      exp_q.delete(); rq_addr.delete(); rq_len.delete(); rq_desc.delete();
      fb_words.delete(); fb_reqs.delete(); fb_sof.delete(); fb_eof.delete();
      sof_id_q.delete(); eof_words_q.delete();
      fb_words.push_back(0); fb_reqs.push_back(0); fb_sof.push_back(0); fb_eof.push_back(0);
      for (int f = 0; f < nf; f++) begin
         int unsigned cmd = d_cmd[idx];
         int unsigned len = cmd & 32'hFFF;
         int unsigned a = d_buf[idx];
         int unsigned rem = len;
         rq_addr.push_back(DBASE + idx*16); rq_len.push_back(4); rq_desc.push_back(1'b1); reqs++;
         while (rem > 0) begin
            int unsigned n = (rem < bw) ? rem : bw;
            rq_addr.push_back(a); rq_len.push_back(n); rq_desc.push_back(1'b0); reqs++;
            a += 4*n; rem -= n;
         end
         for (int unsigned k = 0; k < len; k++)
            exp_q.push_back({cmd[12], mem[d_buf[idx]/4 + k]});
         words += len;
         if (cmd[15]) begin sof_id_q.push_back(d_id[idx]); sofs++; end
         if (cmd[16]) begin eof_words_q.push_back(words); eofs++; end
         fb_words.push_back(words); fb_reqs.push_back(reqs);
         fb_sof.push_back(sofs); fb_eof.push_back(eofs);
         idx = d_next[idx];
      end
   endtask

   // memory responder: random accept delay, random beat gaps
   initial begin
      forever begin
         @(posedge clk); #1;
         rd_req_ready = 1'b0; rd_rsp_valid = 1'b0;
         if (rd_req_valid && ($urandom_range(0, 2) != 0)) begin
            logic [31:0] a;
            int unsigned n;
            rd_req_ready = 1'b1; a = rd_req_addr; n = rd_req_len;
            @(posedge clk); #1;
            rd_req_ready = 1'b0;
            for (int unsigned k = 0; k < n; ) begin
               if ($urandom_range(0, 3) != 0) begin
                  rd_rsp_valid = 1'b1; rd_rsp_data = mem[(a >> 2) + k]; k++;
               end else rd_rsp_valid = 1'b0;
               @(posedge clk); #1;
            end
            rd_rsp_valid = 1'b0;
         end
      end
   end

   // consumer with data check
   initial begin
      forever begin
         @(posedge clk); #1;
         pix_pop = 1'b0;
         if (force_pop) pix_pop = 1'b1;
         else if (pix_valid && ($urandom_range(1, 100) <= pop_pct)) begin
            pix_pop = 1'b1;
            if (popped < exp_q.size()) begin
               if (pix_pal !== exp_q[popped][32])
                  chk(1'b0, "R10", "palette tag", pix_pal, exp_q[popped][32]);
               else
                  chk(pix_data === exp_q[popped][31:0], "R3", "data word", pix_data, exp_q[popped][31:0]);
            end else chk(1'b0, "R3", "extra word", popped, exp_q.size());
            popped++;
         end
      end
   end

   // request, response and interrupt monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (stall_prev)
            chk(rd_req_valid && rd_req_addr == stall_addr && rd_req_len == stall_len,
                "R5", "stalled request changed", rd_req_addr, stall_addr);
         stall_prev = rd_req_valid && !rd_req_ready;
         stall_addr = rd_req_addr; stall_len = rd_req_len;
         if (rd_req_valid && rd_req_ready) begin
            if (req_seen < rq_addr.size()) begin
               cur_is_desc = rq_desc[req_seen];
               if (cur_is_desc)
                  chk(rd_req_addr == rq_addr[req_seen] && rd_req_len == 5'd4,
                      (req_seen == 0) ? "R1" : "R7", "descriptor read", rd_req_addr, rq_addr[req_seen]);
               else begin
                  chk(rd_req_addr == rq_addr[req_seen] && rd_req_len == rq_len[req_seen],
                      "R4", "burst addr/len", {rd_req_addr, 3'b0, rd_req_len}, {rq_addr[req_seen], 8'(rq_len[req_seen])});
                  chk(FIFO_DEPTH - (data_rx - popped) >= cur_bw, "R6", "room at burst",
                      FIFO_DEPTH - (data_rx - popped), cur_bw);
               end
            end else chk(1'b0, "R11", "unexpected request", rd_req_addr, 0);
            req_seen++;
         end
         if (rd_rsp_valid && !cur_is_desc) data_rx++;
         if (irq_sof) begin
            if (sof_cnt < sof_id_q.size())
               chk(cur_frame_id == sof_id_q[sof_cnt], "R8", "frame tag at sof", cur_frame_id, sof_id_q[sof_cnt]);
            sof_cnt++;
         end
         if (irq_eof) begin
            if (eof_cnt < eof_words_q.size())
               chk(data_rx == eof_words_q[eof_cnt], "R9", "words before eof", data_rx, eof_words_q[eof_cnt]);
            eof_cnt++;
         end
      end
   end

   task automatic run_scn(input int unsigned start, input int unsigned bsel,
                          input int unsigned stop_after, input int unsigned pct);
      int k = -1;
      build_exp(start, bsel, 60);
      popped = 0; req_seen = 0; data_rx = 0; sof_cnt = 0; eof_cnt = 0;
      pop_pct = pct; cur_bw = bw_of(bsel); cur_is_desc = 1'b1;
      desc_ptr = DBASE + start*16; burst_sel = 2'(bsel); run_en = 1'b1;
      @(posedge clk); #1; @(posedge clk); #1;
      chk(ufl_flag == 1'b0, "R12", "flag cleared by enable", ufl_flag, 0);
      while (popped < stop_after) @(posedge clk);
      #1 run_en = 1'b0;
      do @(posedge clk); while (busy);
      while (pix_valid) @(posedge clk);
      repeat (4) @(posedge clk);
      #1;
      chk(!busy && !rd_req_valid, "R11", "parked after stop", busy, 0);
      for (int i = 1; i < fb_reqs.size(); i++) if (fb_reqs[i] == req_seen) k = i;
      chk(k > 0, "R11", "stop on frame boundary (requests)", req_seen, 0);
      if (k > 0) begin
         chk(popped == fb_words[k], "R11", "words at stop", popped, fb_words[k]);
         chk(sof_cnt == fb_sof[k], "R8", "sof count", sof_cnt, fb_sof[k]);
         chk(eof_cnt == fb_eof[k], "R9", "eof count", eof_cnt, fb_eof[k]);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 6144; i++) mem[i] = pat(i);
      // A -> B -> B (self link)
      set_desc(0, 1, 32'h0100, 32'h11, (1 << 15) | (1 << 16) | 10);
      set_desc(1, 1, 32'h0800, 32'h22, (1 << 12) | (1 << 15) | 37);
      // C(len 0) -> D(len 1) -> E(len 17) -> C
      set_desc(2, 3, 32'h1000, 32'h33, (1 << 15) | (1 << 16));
      set_desc(3, 8, 32'h1200, 32'h44, (1 << 16) | 1);
      set_desc(8, 2, 32'h1400, 32'h55, (1 << 15) | (1 << 12) | 17);

      // R2: reset state
      repeat (3) @(posedge clk);
      #1;
      chk(!rd_req_valid && !pix_valid && !busy, "R2", "outputs in reset", {rd_req_valid, pix_valid, busy}, 0);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk(!rd_req_valid && !pix_valid && !busy, "R2", "idle after reset", {rd_req_valid, pix_valid, busy}, 0);
      chk(!irq_sof && !irq_eof && !ufl_flag && !irq_ufl, "R2", "flags after reset",
          {irq_sof, irq_eof, ufl_flag, irq_ufl}, 0);

      run_scn(0, 0, 100, 70);   // R1 R3 R7 self link, 4-word bursts
      run_scn(0, 2, 60, 15);    // R6 slow consumer, 16-word bursts
      run_scn(2, 1, 30, 60);    // R3 zero length, R4 8-word bursts

      // R12: underrun with mask set, then cleared
      ufl_mask = 1'b1;
      @(negedge clk); force_pop = 1'b1;
      @(negedge clk); force_pop = 1'b0;
      @(posedge clk); #2;
      chk(ufl_flag == 1'b1, "R12", "flag after empty pop", ufl_flag, 1);
      chk(irq_ufl == 1'b0, "R12", "masked irq", irq_ufl, 0);
      ufl_mask = 1'b0; #1;
      chk(irq_ufl == 1'b1, "R12", "unmasked irq", irq_ufl, 1);
      repeat (3) @(posedge clk);
      #1 chk(ufl_flag == 1'b1, "R12", "flag sticky", ufl_flag, 1);

      // random chains 4->5->6->7->5, burst select includes code 3 (R4)
      for (int r = 0; r < 4; r++) begin
         for (int unsigned i = 4; i < 8; i++)
            set_desc(i, (i == 7) ? 5 : i + 1, $urandom_range(0, 3900) * 4, $urandom,
                     ($urandom_range(0, 1) << 12) | ($urandom_range(0, 1) << 15) |
                     ($urandom_range(0, 1) << 16) | $urandom_range(0, 40));
         run_scn(4, (r == 0) ? 3 : $urandom_range(0, 3), 50 + $urandom_range(0, 80),
                 $urandom_range(10, 100));
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         summary();
         $finish;
      end
   end

endmodule